// File: doc/BRIEF.md
# Trap and Interrupt Control Registers

This block holds the exception state of a simple in-order processor. It keeps a saved-PC register, a cause register and a two-bit status register. The status register holds a global interrupt-enable flag and a privilege flag, where 1 means kernel mode. At the commit point the pipeline presents three kinds of request: a synchronous trap request, prioritized external interrupt request lines, and a return-from-exception strobe. The block decides which request is accepted, updates its registers and issues a one-cycle fetch redirect with the target PC.

A synchronous request is either a restartable exception or a completed trap. A restartable exception saves the faulting PC, so the instruction runs again after the handler. A completed trap, such as a multiply emulated in software, saves the PC plus 4. The two kinds vector to different fixed handler addresses.

A handler can read and write the saved PC, the cause and the status through a small register port. This lets it save the return address before it re-enables interrupts for nesting.

Top module: `trap_ctrl_regs`

## Requirements
- R1: After reset the block is in kernel mode with interrupts disabled, the saved PC and cause read as zero, and no redirect is signalled.
- R2: A trap request of kind 0 (restartable exception) saves `trap_pc` and stores cause `{0, trap_code}`. It clears interrupt enable and enters kernel mode. In the next cycle it pulses `redirect_valid` with `redirect_pc` equal to `EXC_VEC` (default 0x80).
- R3: A trap request of kind 1 (completed trap) saves `trap_pc + 4`, with the same cause and status effects as R2. It redirects to `TRAP_VEC` (default 0x1010).
- R4: When interrupts are enabled and any request line is high, the lowest-numbered high line is accepted. This saves `irq_pc`, stores cause 16 + line index, clears interrupt enable, enters kernel mode and redirects to `EXC_VEC`.
- R5: While interrupt enable is clear, the request lines have no effect: registers and redirect stay unchanged.
- R6: An accepted interrupt takes precedence over a trap request in the same cycle, and that trap request is dropped.
- R7: A return strobe sets interrupt enable, selects user mode and redirects to the saved PC value held before that cycle.
- R8: A trap request together with a return strobe in the same cycle is handled as the trap, and the return is dropped.
- R9: Register port select codes are: 0 = saved PC, 1 = cause, 2 = status (bit 0 interrupt enable, bit 1 kernel mode), 3 = unused (reads zero, writes ignored). Reads are combinational, and a write is visible from the next cycle.
- R10: `redirect_valid` is high only in the cycle after an accepted event. A register write made in the same cycle as an accepted event is discarded.
- R11: A synchronous trap request is accepted even while interrupt enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Synchronous trap request strobe |
| trap_kind | input | 1 | 0 = restartable exception, 1 = completed trap |
| trap_code | input | CODE_W | Cause code of the trap request |
| trap_pc | input | XLEN | PC of the trapping instruction |
| irq_lines | input | NIRQ | External interrupt request lines, line 0 highest priority |
| irq_pc | input | XLEN | PC of the instruction at the commit point |
| eret | input | 1 | Return-from-exception strobe |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select |
| csr_wdata | input | XLEN | Register write data |
| csr_rdata | output | XLEN | Register read data |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | XLEN | Redirect target |
| kernel_mode | output | 1 | 1 = kernel mode |
| int_en | output | 1 | Global interrupt enable |

## Verification
The assertions check on every cycle how each accepted event shapes the next cycle's redirect, vector and status. They also check that no redirect appears without an event, and that request lines are inert while interrupts are disabled. Only the bench's scenarios and its reference model can show the stored values. These include the saved PC versus PC+4, the encoded cause with the line priority, the return target taken from the saved PC, and register writes that are dropped in favour of an event, all read back through the register port.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_IRQ,
    EV_EXC,
    EV_TRAP,
    EV_RET,
    EV_WR
  } trap_ev_e;

  typedef enum logic [1:0] {
    SEL_EPC    = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } csr_sel_e;

  localparam int unsigned ST_IE_BIT = 0;
  localparam int unsigned ST_KM_BIT = 1;

endpackage

// File: rtl/trap_rst_sync.sv
module trap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;
endmodule

// File: rtl/trap_irq_arb.sv
module trap_irq_arb #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  lines,
  input  logic          en,
  output logic          take,
  output logic [IW-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant[g]  = lines[g] & ~seen[g];
    assign seen[g+1] = seen[g] | lines[g];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end

  assign take = en & seen[N];
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int unsigned         XLEN     = 32,
  parameter int unsigned         CODE_W   = 4,
  parameter int unsigned         IW       = 2,
  parameter logic [XLEN-1:0]     EXC_VEC  = 32'h0000_0080,
  parameter logic [XLEN-1:0]     TRAP_VEC = 32'h0000_1010
) (
  input  logic              irq_take,
  input  logic [IW-1:0]     irq_idx,
  input  logic [XLEN-1:0]   irq_pc,
  input  logic              trap_req,
  input  logic              trap_kind,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              eret,
  input  logic              csr_we,
  input  logic [XLEN-1:0]   epc_q,
  output trap_ev_e          ev,
  output logic [XLEN-1:0]   nxt_epc,
  output logic [CODE_W:0]   nxt_cause,
  output logic              nxt_ie,
  output logic              nxt_km,
  output logic [XLEN-1:0]   tgt_pc
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  always_comb begin
    ev        = EV_NONE;
    nxt_epc   = epc_q;
    nxt_cause = '0;
    nxt_ie    = 1'b0;
    nxt_km    = 1'b1;
    tgt_pc    = EXC_VEC;
    if (irq_take) begin
      ev        = EV_IRQ;
      nxt_epc   = irq_pc;
      nxt_cause = {1'b1, CODE_W'(irq_idx)};
    end else if (trap_req) begin
      nxt_cause = {1'b0, trap_code};
      if (trap_kind) begin
        ev      = EV_TRAP;
        nxt_epc = trap_pc + PC_STEP;
        tgt_pc  = TRAP_VEC;
      end else begin
        ev      = EV_EXC;
        nxt_epc = trap_pc;
      end
    end else if (eret) begin
      ev     = EV_RET;
      nxt_ie = 1'b1;
      nxt_km = 1'b0;
      tgt_pc = epc_q;
    end else if (csr_we) begin
      ev = EV_WR;
    end
  end
endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  trap_ev_e        ev,
  input  logic [XLEN-1:0] nxt_epc,
  input  logic [CODE_W:0] nxt_cause,
  input  logic            nxt_ie,
  input  logic            nxt_km,
  input  logic [XLEN-1:0] tgt_pc,
  input  logic [1:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] csr_rdata,
  output logic            ie_q,
  output logic            km_q,
  output logic            rv_q,
  output logic [XLEN-1:0] rpc_q
);
  localparam int unsigned CAUSE_W = CODE_W + 1;

  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [XLEN-1:0]    epc_d, rpc_d;
  logic               ie_d, km_d, rv_d;
  logic               epc_en, cause_en, st_en, rpc_en;
  logic               is_entry, is_wr;

  always_comb begin
    is_entry = (ev == EV_IRQ) || (ev == EV_EXC) || (ev == EV_TRAP);
    is_wr    = (ev == EV_WR);

    epc_en   = is_entry || (is_wr && csr_sel == SEL_EPC);
    epc_d    = is_wr ? csr_wdata : nxt_epc;

    cause_en = is_entry || (is_wr && csr_sel == SEL_CAUSE);
    cause_d  = is_wr ? csr_wdata[CAUSE_W-1:0] : nxt_cause;

    st_en    = is_entry || (ev == EV_RET) || (is_wr && csr_sel == SEL_STATUS);
    ie_d     = is_wr ? csr_wdata[ST_IE_BIT] : nxt_ie;
    km_d     = is_wr ? csr_wdata[ST_KM_BIT] : nxt_km;

    rv_d     = is_entry || (ev == EV_RET);
    rpc_en   = rv_d;
    rpc_d    = tgt_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      ie_q    <= 1'b0;
      km_q    <= 1'b1;
      rv_q    <= 1'b0;
      rpc_q   <= '0;
    end else begin
      if (epc_en)   epc_q   <= epc_d;
      if (cause_en) cause_q <= cause_d;
      if (st_en) begin
        ie_q <= ie_d;
        km_q <= km_d;
      end
      rv_q <= rv_d;
      if (rpc_en)   rpc_q   <= rpc_d;
    end
  end

  always_comb begin
    csr_rdata = '0;
    unique case (csr_sel)
      SEL_EPC:    csr_rdata = epc_q;
      SEL_CAUSE:  csr_rdata = XLEN'(cause_q);
      SEL_STATUS: begin
        csr_rdata[ST_IE_BIT] = ie_q;
        csr_rdata[ST_KM_BIT] = km_q;
      end
      default:    csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trap_ctrl_regs.sv
module trap_ctrl_regs
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     NIRQ     = 4,
  parameter int unsigned     CODE_W   = 4,
  parameter logic [XLEN-1:0] EXC_VEC  = 32'h0000_0080,
  parameter logic [XLEN-1:0] TRAP_VEC = 32'h0000_1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic              trap_kind,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [NIRQ-1:0]   irq_lines,
  input  logic [XLEN-1:0]   irq_pc,
  input  logic              eret,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              kernel_mode,
  output logic              int_en
);
  localparam int unsigned IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  logic            arst_n_sync;
  logic            irq_take;
  logic [IW-1:0]   irq_idx;
  trap_ev_e        ev;
  logic [XLEN-1:0] nxt_epc, tgt_pc, epc_q;
  logic [CODE_W:0] nxt_cause;
  logic            nxt_ie, nxt_km;

  trap_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (arst_n_sync)
  );

  trap_irq_arb #(.N(NIRQ), .IW(IW)) u_arb (
    .lines (irq_lines),
    .en    (int_en),
    .take  (irq_take),
    .idx   (irq_idx)
  );

  trap_sequencer #(
    .XLEN(XLEN), .CODE_W(CODE_W), .IW(IW),
    .EXC_VEC(EXC_VEC), .TRAP_VEC(TRAP_VEC)
  ) u_seq (
    .irq_take  (irq_take),
    .irq_idx   (irq_idx),
    .irq_pc    (irq_pc),
    .trap_req  (trap_req),
    .trap_kind (trap_kind),
    .trap_code (trap_code),
    .trap_pc   (trap_pc),
    .eret      (eret),
    .csr_we    (csr_we),
    .epc_q     (epc_q),
    .ev        (ev),
    .nxt_epc   (nxt_epc),
    .nxt_cause (nxt_cause),
    .nxt_ie    (nxt_ie),
    .nxt_km    (nxt_km),
    .tgt_pc    (tgt_pc)
  );

  trap_csr_file #(.XLEN(XLEN), .CODE_W(CODE_W)) u_regs (
    .clk       (clk),
    .rst_n     (arst_n_sync),
    .ev        (ev),
    .nxt_epc   (nxt_epc),
    .nxt_cause (nxt_cause),
    .nxt_ie    (nxt_ie),
    .nxt_km    (nxt_km),
    .tgt_pc    (tgt_pc),
    .csr_sel   (csr_sel),
    .csr_wdata (csr_wdata),
    .epc_q     (epc_q),
    .csr_rdata (csr_rdata),
    .ie_q      (int_en),
    .km_q      (kernel_mode),
    .rv_q      (redirect_valid),
    .rpc_q     (redirect_pc)
  );
endmodule

// File: rtl/trap_ctrl_regs_chk.sv
module trap_ctrl_regs_chk #(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     NIRQ     = 4,
  parameter logic [XLEN-1:0] EXC_VEC  = 32'h0000_0080,
  parameter logic [XLEN-1:0] TRAP_VEC = 32'h0000_1010
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            trap_req,
  input logic            trap_kind,
  input logic [NIRQ-1:0] irq_lines,
  input logic            eret,
  input logic            csr_we,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic            kernel_mode,
  input logic            int_en
);
  logic irq_live;
  assign irq_live = int_en && (|irq_lines);

  // R2
  exc_vector_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (trap_req && !trap_kind && !irq_live) |=>
      (redirect_valid && redirect_pc == EXC_VEC && !int_en && kernel_mode));

  // R3
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (trap_req && trap_kind && !irq_live) |=>
      (redirect_valid && redirect_pc == TRAP_VEC && !int_en && kernel_mode));

  // R4
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_live |=> (redirect_valid && redirect_pc == EXC_VEC && !int_en && kernel_mode));

  // R5
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!int_en && !trap_req && !eret && !csr_we) |=>
      (!redirect_valid && !int_en && $stable(kernel_mode)));

  // R7
  eret_mode_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (eret && !trap_req && !irq_live) |=> (redirect_valid && int_en && !kernel_mode));

  // R8
  trap_beats_ret_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (trap_req && eret) |=> (redirect_valid && kernel_mode && !int_en));

  // R10
  no_idle_redirect_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!trap_req && !eret && !irq_live) |=> !redirect_valid);
endmodule

bind trap_ctrl_regs trap_ctrl_regs_chk #(
  .XLEN(XLEN), .NIRQ(NIRQ), .EXC_VEC(EXC_VEC), .TRAP_VEC(TRAP_VEC)
) u_chk (
  .clk            (clk),
  .rst_ok         (arst_n_sync),
  .trap_req       (trap_req),
  .trap_kind      (trap_kind),
  .irq_lines      (irq_lines),
  .eret           (eret),
  .csr_we         (csr_we),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .kernel_mode    (kernel_mode),
  .int_en         (int_en)
);

// File: tb/sim_trap_ctrl_regs.sv
`timescale 1ns/1ps
module sim_trap_ctrl_regs;
  localparam int XLEN = 32;
  localparam int NIRQ = 4;
  localparam int CODE_W = 4;
  localparam logic [31:0] EV = 32'h80;
  localparam logic [31:0] TV = 32'h1010;

  logic clk = 1'b0;
  logic rst_n;
  logic trap_req, trap_kind, eret, csr_we;
  logic [CODE_W-1:0] trap_code;
  logic [XLEN-1:0] trap_pc, irq_pc, csr_wdata;
  logic [NIRQ-1:0] irq_lines;
  logic [1:0] csr_sel;
  logic [XLEN-1:0] csr_rdata, redirect_pc;
  logic redirect_valid, kernel_mode, int_en;

  always #2.5 clk = ~clk;

  trap_ctrl_regs u0 (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_kind(trap_kind),
    .trap_code(trap_code), .trap_pc(trap_pc), .irq_lines(irq_lines),
    .irq_pc(irq_pc), .eret(eret), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .kernel_mode(kernel_mode), .int_en(int_en)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_epc, m_rpc;
  logic [4:0]  m_cause;
  logic        m_ie, m_km, m_rv;
  int          m_rcnt;

  task automatic m_reset();
    m_epc = 0; m_rpc = 0; m_cause = 0; m_ie = 0; m_km = 1; m_rv = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rcnt = 0; m_reset();
    end else if (m_rcnt < 2) begin
      m_rcnt++; m_reset();
    end else begin
      int hit;
      hit = -1;
      for (int i = NIRQ-1; i >= 0; i--) if (irq_lines[i]) hit = i;
      m_rv = 0;
      if (m_ie && hit >= 0) begin
        m_epc = irq_pc; m_cause = 5'(16 + hit); m_ie = 0; m_km = 1;
        m_rv = 1; m_rpc = EV;
      end else if (trap_req) begin
        m_epc = trap_kind ? trap_pc + 4 : trap_pc;
        m_cause = {1'b0, trap_code}; m_ie = 0; m_km = 1;
        m_rv = 1; m_rpc = trap_kind ? TV : EV;
      end else if (eret) begin
        m_rv = 1; m_rpc = m_epc; m_ie = 1; m_km = 0;
      end else if (csr_we) begin
        case (csr_sel)
          2'd0: m_epc = csr_wdata;
          2'd1: m_cause = csr_wdata[4:0];
          2'd2: begin m_ie = csr_wdata[0]; m_km = csr_wdata[1]; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] s);
    case (s)
      2'd0: return m_epc;
      2'd1: return {27'd0, m_cause};
      2'd2: return {30'd0, m_km, m_ie};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    trap_req = 0; trap_kind = 0; trap_code = 0; trap_pc = 0;
    irq_lines = 0; irq_pc = 0; eret = 0; csr_we = 0; csr_wdata = 0;
  endtask

  // advance one clock, then compare everything against the model
  task automatic tick(input string req);
    @(posedge clk);
    @(negedge clk);
    check(req, "redirect_valid", 32'(redirect_valid), 32'(m_rv));
    check(req, "redirect_pc", redirect_pc, m_rpc);
    check(req, "kernel_mode", 32'(kernel_mode), 32'(m_km));
    check(req, "int_en", 32'(int_en), 32'(m_ie));
    check(req, "csr_rdata", csr_rdata, m_read(csr_sel));
  endtask

  task automatic rd(input string req, input logic [1:0] s, input logic [31:0] exp);
    csr_sel = s; #0.1;
    check(req, "read", csr_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); csr_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "kernel", 32'(kernel_mode), 1);
    check("R1", "ie", 32'(int_en), 0);
    check("R1", "rv", 32'(redirect_valid), 0);
    rd("R1", 0, 0);
    rd("R1", 1, 0);

    // R2 / R11 exception while interrupts disabled
    trap_req = 1; trap_kind = 0; trap_code = 4'd3; trap_pc = 32'h200;
    tick("R2"); idle();
    check("R11", "rv", 32'(redirect_valid), 1);
    check("R2", "vector", redirect_pc, EV);
    rd("R2", 0, 32'h200);
    rd("R2", 1, 32'h3);
    tick("R10");
    check("R10", "single pulse", 32'(redirect_valid), 0);

    // R3 completed trap
    trap_req = 1; trap_kind = 1; trap_code = 4'd8; trap_pc = 32'h11a0;
    tick("R3"); idle();
    check("R3", "vector", redirect_pc, TV);
    rd("R3", 0, 32'h11a4);

    // R7 return
    eret = 1; tick("R7"); idle();
    check("R7", "target", redirect_pc, 32'h11a4);
    check("R7", "user", 32'(kernel_mode), 0);
    check("R7", "ie", 32'(int_en), 1);

    // R4 interrupt, lowest line wins
    irq_lines = 4'b0110; irq_pc = 32'h3000; tick("R4"); idle();
    rd("R4", 1, 32'd17);
    rd("R4", 0, 32'h3000);
    check("R4", "vector", redirect_pc, EV);

    // R5 lines ignored while disabled
    irq_lines = 4'b1111; irq_pc = 32'h5000; tick("R5"); idle();
    check("R5", "rv", 32'(redirect_valid), 0);
    rd("R5", 0, 32'h3000);

    // R9 register writes
    csr_we = 1; csr_sel = 0; csr_wdata = 32'h4444; tick("R9"); idle();
    rd("R9", 0, 32'h4444);
    csr_we = 1; csr_sel = 2; csr_wdata = 32'h3; tick("R9"); idle();
    rd("R9", 2, 32'h3);
    csr_we = 1; csr_sel = 3; csr_wdata = 32'hffff; tick("R9"); idle();
    rd("R9", 3, 0);
    rd("R9", 0, 32'h4444);

    // R6 interrupt beats trap (ie now 1)
    irq_lines = 4'b1000; irq_pc = 32'h6000;
    trap_req = 1; trap_kind = 1; trap_code = 4'd5; trap_pc = 32'h7000;
    tick("R6"); idle();
    rd("R6", 1, 32'd19);
    rd("R6", 0, 32'h6000);

    // R8 trap beats return
    trap_req = 1; trap_kind = 0; trap_code = 4'd2; trap_pc = 32'h8000; eret = 1;
    tick("R8"); idle();
    check("R8", "kernel", 32'(kernel_mode), 1);
    check("R8", "vector", redirect_pc, EV);

    // R10 write dropped on event
    eret = 1; csr_we = 1; csr_sel = 0; csr_wdata = 32'h9999; tick("R10"); idle();
    check("R10", "target", redirect_pc, 32'h8000);
    rd("R10", 0, 32'h8000);

    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      trap_req  = ($urandom % 6) == 0;
      trap_kind = $urandom;
      trap_code = $urandom;
      trap_pc   = $urandom & 32'hfffc;
      irq_lines = (($urandom % 5) == 0) ? 4'($urandom) : 4'd0;
      irq_pc    = $urandom & 32'hfffc;
      eret      = ($urandom % 5) == 0;
      csr_we    = ($urandom % 4) == 0;
      csr_sel   = $urandom;
      csr_wdata = $urandom;
      tick("R10");
    end
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule